// File: doc/BRIEF.md
# Space-Tagged Translation Lookaside Buffer

This block is a fully associative translation cache. A global virtual address is a 16-bit space identifier joined to a 32-bit offset. With 4 KiB pages the top 20 offset bits form the virtual page number, and the block returns a 20-bit physical page number. Every entry carries the space identifier it was loaded under. Because of that tag, translations from different processes sit side by side, and a context switch needs no flush. Two spaces that both use offset zero resolve to separate entries.

The lookup port is combinational against the entry registers, so the hit flag and the page number come back in the same cycle as the request. Refill logic, either software or a table walker, loads entries through the insert port. The purge port removes either one exact (space, page) entry or every entry of one space. A whole-space purge takes one cycle, and lookups are stalled during that cycle. A refill goes to the lowest-numbered free entry. When no entry is free, a round-robin pointer picks the entry to evict. Reloading a (space, page) pair that is already present rewrites that entry in place.

Top module: `space_tlb`

## Requirements
- R1: After reset every entry is invalid and the round-robin pointer is 0. A lookup then reports `lk_hit`=0, `lk_ppn`=0 and `lk_stall`=0.
- R2: A lookup hits only when some valid entry has both `lk_space` and `lk_vpn` equal to its stored tag. It returns `lk_hit`=1 and that entry's page number combinationally, in the cycle of the request. On a miss `lk_ppn` is 0.
- R3: The same virtual page number loaded under two different space identifiers occupies two entries, and each lookup returns its own translation.
- R4: An insert of a new key writes the lowest-indexed invalid entry when one exists. No valid entry is evicted in that case.
- R5: When every entry is valid, an insert of a new key replaces the entry at the round-robin pointer. The pointer starts at 0 and advances by one, modulo the entry count, after each such eviction.
- R6: When `pg_whole`=0, a purge clears only the entry whose space and page both match. When `pg_whole`=1, a purge clears every entry whose space matches `pg_space`, and entries of other spaces are kept. The result is visible from the next cycle.
- R7: During a cycle with `pg_valid`=1 and `pg_whole`=1, `lk_stall` is 1 and `lk_hit` is 0.
- R8: An insert whose space and page already exist rewrites that entry's page number in place. It takes no new entry and evicts nothing.
- R9: When a purge and an insert are presented in the same cycle, the purge is applied and the insert is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_valid | input | 1 | Lookup request |
| lk_space | input | 16 | Lookup space identifier |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 20 | Physical page number on hit, 0 on miss |
| lk_stall | output | 1 | Lookup stalled by a whole-space purge |
| ins_valid | input | 1 | Insert request |
| ins_space | input | 16 | Insert space identifier |
| ins_vpn | input | 20 | Insert virtual page number |
| ins_ppn | input | 20 | Insert physical page number |
| pg_valid | input | 1 | Purge request |
| pg_whole | input | 1 | 1: purge the whole space; 0: purge one exact entry |
| pg_space | input | 16 | Purge space identifier |
| pg_vpn | input | 20 | Purge virtual page number, used only when `pg_whole`=0 |

## Verification
A corrupted valid bit, tag or pointer inside the block shows up at the lookup port in the first lookup of the affected key after the corruption. The symptom is a miss where a hit was expected, a hit on a purged or evicted key, or a stale page number. A wrong choice of victim stays hidden until the table fills up. It then appears as the wrong earlier translation missing on the next lookup. For that reason the bench fills every entry and then probes exactly which key was evicted after each replacement.

// File: rtl/space_tlb_pkg.sv
package space_tlb_pkg;

  typedef enum logic [1:0] {
    OP_IDLE        = 2'd0,
    OP_INSERT      = 2'd1,
    OP_PURGE_ONE   = 2'd2,
    OP_PURGE_SPACE = 2'd3
  } tlb_op_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N         = 16,
  parameter int SID_W     = 16,
  parameter int VPN_W     = 20,
  parameter bit MATCH_VPN = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N-1:0]                vld,
  input  logic [N-1:0][SID_W-1:0]     sid,
  input  logic [N-1:0][VPN_W-1:0]     vpn,
  input  logic [SID_W-1:0]            key_sid,
  input  logic [VPN_W-1:0]            key_vpn,
  output logic [N-1:0]                hit_vec
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic sid_eq;
    logic vpn_eq;
    assign sid_eq     = (sid[i] == key_sid);
    assign vpn_eq     = (vpn[i] == key_vpn);
    assign hit_vec[i] = vld[i] && sid_eq && (!MATCH_VPN || vpn_eq);
  end

  if (MATCH_VPN) begin : g_exact_chk
    // R8: a (space, page) key never lives in two entries
    a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] vld,
  input  logic         take,
  output logic [N-1:0] sel
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [N-1:0]     free_sel;
  logic             any_free;

  always_comb begin
    free_sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_sel    = '0;
        free_sel[i] = 1'b1;
      end
    end
    any_free = !(&vld);
  end

  always_comb begin
    sel = '0;
    if (any_free) sel = free_sel;
    else          sel[ptr_q] = 1'b1;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (take && !any_free) begin
      if (ptr_q == IDX_W'(N - 1)) ptr_d = '0;
      else                        ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R4 / R5: every refill lands in exactly one entry
  a_r5_victim_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $onehot(sel));

  // R4: a free entry is chosen over an occupied one
  a_r4_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(&vld)) |-> ((sel & vld) == '0));

endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N     = 16,
  parameter int SID_W = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            wr_vec,
  input  logic [N-1:0]            clr_vec,
  input  logic [SID_W-1:0]        w_sid,
  input  logic [VPN_W-1:0]        w_vpn,
  input  logic [PPN_W-1:0]        w_ppn,
  output logic [N-1:0]            vld,
  output logic [N-1:0][SID_W-1:0] sid,
  output logic [N-1:0][VPN_W-1:0] vpn,
  output logic [N-1:0][PPN_W-1:0] ppn
);

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic vld_d;

    always_comb begin
      vld_d = vld[i];
      if (clr_vec[i])     vld_d = 1'b0;
      else if (wr_vec[i]) vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld[i] <= 1'b0;
      else        vld[i] <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (wr_vec[i]) begin
        sid[i] <= w_sid;
        vpn[i] <= w_vpn;
        ppn[i] <= w_ppn;
      end
    end
  end

endmodule

// File: rtl/space_tlb.sv
module space_tlb #(
  parameter int ENTRIES = 16,
  parameter int SID_W   = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [SID_W-1:0] lk_space,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_stall,
  input  logic             ins_valid,
  input  logic [SID_W-1:0] ins_space,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic             pg_valid,
  input  logic             pg_whole,
  input  logic [SID_W-1:0] pg_space,
  input  logic [VPN_W-1:0] pg_vpn
);

  import space_tlb_pkg::*;

  tlb_op_e                        op;
  logic [ENTRIES-1:0]             vld;
  logic [ENTRIES-1:0][SID_W-1:0]  sid;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn;
  logic [ENTRIES-1:0]             lk_vec, ins_vec, pg_vec, pgs_vec;
  logic [ENTRIES-1:0]             vic_sel, wr_vec, clr_vec;
  logic                           take;
  logic [PPN_W-1:0]               ppn_or;

  // purge outranks insert (R9)
  always_comb begin
    if (pg_valid)       op = pg_whole ? OP_PURGE_SPACE : OP_PURGE_ONE;
    else if (ins_valid) op = OP_INSERT;
    else                op = OP_IDLE;
  end

  tlb_match #(.N(ENTRIES), .SID_W(SID_W), .VPN_W(VPN_W), .MATCH_VPN(1'b1)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .vld(vld), .sid(sid), .vpn(vpn),
    .key_sid(lk_space), .key_vpn(lk_vpn), .hit_vec(lk_vec));

  tlb_match #(.N(ENTRIES), .SID_W(SID_W), .VPN_W(VPN_W), .MATCH_VPN(1'b1)) u_ins_match (
    .clk(clk), .rst_n(rst_n), .vld(vld), .sid(sid), .vpn(vpn),
    .key_sid(ins_space), .key_vpn(ins_vpn), .hit_vec(ins_vec));

  tlb_match #(.N(ENTRIES), .SID_W(SID_W), .VPN_W(VPN_W), .MATCH_VPN(1'b1)) u_pg_match (
    .clk(clk), .rst_n(rst_n), .vld(vld), .sid(sid), .vpn(vpn),
    .key_sid(pg_space), .key_vpn(pg_vpn), .hit_vec(pg_vec));

  tlb_match #(.N(ENTRIES), .SID_W(SID_W), .VPN_W(VPN_W), .MATCH_VPN(1'b0)) u_pgs_match (
    .clk(clk), .rst_n(rst_n), .vld(vld), .sid(sid), .vpn(vpn),
    .key_sid(pg_space), .key_vpn(pg_vpn), .hit_vec(pgs_vec));

  assign take = (op == OP_INSERT) && !(|ins_vec);

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .vld(vld), .take(take), .sel(vic_sel));

  always_comb begin
    wr_vec  = '0;
    clr_vec = '0;
    case (op)
      OP_INSERT:      wr_vec  = (|ins_vec) ? ins_vec : vic_sel;
      OP_PURGE_ONE:   clr_vec = pg_vec;
      OP_PURGE_SPACE: clr_vec = pgs_vec;
      default:        ;
    endcase
  end

  tlb_store #(.N(ENTRIES), .SID_W(SID_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_vec(wr_vec), .clr_vec(clr_vec),
    .w_sid(ins_space), .w_vpn(ins_vpn), .w_ppn(ins_ppn),
    .vld(vld), .sid(sid), .vpn(vpn), .ppn(ppn));

  always_comb begin
    ppn_or = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_vec[i]) ppn_or = ppn_or | ppn[i];
    end
  end

  assign lk_stall = (op == OP_PURGE_SPACE);
  assign lk_hit   = lk_valid && !lk_stall && (|lk_vec);
  assign lk_ppn   = lk_hit ? ppn_or : '0;

  // R7: a whole-space purge blocks lookups in its cycle
  a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_valid && pg_whole) |-> (lk_stall && !lk_hit));

  // R2: a miss never leaks a page number
  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ppn == '0));

  // R9: an insert beside a purge brings no entry to life
  a_r9_purge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_valid && ins_valid) |=> ((vld & ~$past(vld)) == '0));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    // R6: every entry of a purged space is gone next cycle
    a_r6_space_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_valid && pg_whole && vld[i] && (sid[i] == pg_space)) |=> !vld[i]);
  end

endmodule

// File: tb/space_tlb_tb_top.sv
module space_tlb_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, ins_valid, pg_valid, pg_whole;
  logic [15:0] lk_space, ins_space, pg_space;
  logic [19:0] lk_vpn, ins_vpn, pg_vpn, ins_ppn;
  logic        lk_hit, lk_stall;
  logic [19:0] lk_ppn;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        hit;
    logic [19:0] ppn;
    logic        stall;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  space_tlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_space(lk_space), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_stall(lk_stall),
    .ins_valid(ins_valid), .ins_space(ins_space), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
    .pg_valid(pg_valid), .pg_whole(pg_whole), .pg_space(pg_space), .pg_vpn(pg_vpn));

  // monitor: compares outputs 2 ns after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (lk_valid && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (lk_hit !== e.hit || lk_ppn !== e.ppn || lk_stall !== e.stall) begin
          errors++;
          $display("FAIL %s: hit=%b ppn=%h stall=%b expected hit=%b ppn=%h stall=%b",
                   e.req, lk_hit, lk_ppn, lk_stall, e.hit, e.ppn, e.stall);
        end
      end
    end
  end

  task automatic look(input logic [15:0] s, input logic [19:0] v,
                      input logic eh, input logic [19:0] ep, input string req);
    exp_t e;
    @(negedge clk);
    e.hit = eh; e.ppn = eh ? ep : 20'h0; e.stall = 1'b0; e.req = req;
    exp_q.push_back(e);
    lk_valid = 1'b1; lk_space = s; lk_vpn = v;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic put(input logic [15:0] s, input logic [19:0] v, input logic [19:0] p);
    @(negedge clk);
    ins_valid = 1'b1; ins_space = s; ins_vpn = v; ins_ppn = p;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic purge(input logic whole, input logic [15:0] s, input logic [19:0] v);
    @(negedge clk);
    pg_valid = 1'b1; pg_whole = whole; pg_space = s; pg_vpn = v;
    @(negedge clk);
    pg_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lk_valid = 1'b0; ins_valid = 1'b0; pg_valid = 1'b0; pg_whole = 1'b0;
    lk_space = '0; lk_vpn = '0; ins_space = '0; ins_vpn = '0; ins_ppn = '0;
    pg_space = '0; pg_vpn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    look(16'd1, 20'd5, 1'b0, 20'h0, "R1 empty after reset");

    // offset zero under two spaces
    put(16'd1, 20'd0, 20'h00111);
    put(16'd2, 20'd0, 20'h00222);
    look(16'd1, 20'd0, 1'b1, 20'h00111, "R3 space 1 page 0");
    look(16'd2, 20'd0, 1'b1, 20'h00222, "R3 space 2 page 0");
    look(16'd3, 20'd0, 1'b0, 20'h0,     "R2 unknown space misses");
    look(16'd1, 20'd1, 1'b0, 20'h0,     "R2 unknown page misses");

    put(16'd1, 20'd0, 20'h00333);
    look(16'd1, 20'd0, 1'b1, 20'h00333, "R8 rewrite in place");

    // fill entries 2..15
    for (int k = 2; k < 16; k++) put(16'd5, 20'(k), 20'h00500 + 20'(k));
    look(16'd5, 20'd15, 1'b1, 20'h0050F, "R4 last free entry used");
    look(16'd1, 20'd0,  1'b1, 20'h00333, "R4 no eviction while free");

    // table full: rewriting an existing key must not evict entry 0
    put(16'd5, 20'd2, 20'h00777);
    look(16'd5, 20'd2, 1'b1, 20'h00777, "R8 rewrite when full");
    look(16'd1, 20'd0, 1'b1, 20'h00333, "R8 no eviction on rewrite");

    // evictions follow the pointer 0, then 1
    put(16'd6, 20'd1, 20'h00601);
    look(16'd1, 20'd0, 1'b0, 20'h0,     "R5 entry 0 evicted first");
    look(16'd2, 20'd0, 1'b1, 20'h00222, "R5 entry 1 kept");
    look(16'd6, 20'd1, 1'b1, 20'h00601, "R5 new key present");
    put(16'd6, 20'd2, 20'h00602);
    look(16'd2, 20'd0, 1'b0, 20'h0,     "R5 entry 1 evicted second");
    look(16'd5, 20'd2, 1'b1, 20'h00777, "R5 entry 2 kept");

    // single purge
    purge(1'b0, 16'd5, 20'd3);
    look(16'd5, 20'd3, 1'b0, 20'h0,     "R6 single entry purged");
    look(16'd5, 20'd4, 1'b1, 20'h00504, "R6 neighbour kept");

    // whole-space purge with a concurrent lookup
    begin
      exp_t e;
      @(negedge clk);
      e.hit = 1'b0; e.ppn = 20'h0; e.stall = 1'b1; e.req = "R7 stall during space purge";
      exp_q.push_back(e);
      pg_valid = 1'b1; pg_whole = 1'b1; pg_space = 16'd5; pg_vpn = 20'd0;
      lk_valid = 1'b1; lk_space = 16'd6; lk_vpn = 20'd1;
      @(negedge clk);
      pg_valid = 1'b0; lk_valid = 1'b0;
    end
    look(16'd5, 20'd4,  1'b0, 20'h0,     "R6 space purge clears page 4");
    look(16'd5, 20'd15, 1'b0, 20'h0,     "R6 space purge clears page 15");
    look(16'd6, 20'd1,  1'b1, 20'h00601, "R6 other space kept");
    look(16'd6, 20'd2,  1'b1, 20'h00602, "R6 other space kept 2");

    // free entries exist again: inserting evicts nothing
    put(16'd7, 20'd9, 20'h00079);
    look(16'd7, 20'd9, 1'b1, 20'h00079, "R4 insert into freed entry");
    look(16'd6, 20'd1, 1'b1, 20'h00601, "R4 no eviction after purge");

    // purge and insert together: insert discarded
    @(negedge clk);
    pg_valid = 1'b1; pg_whole = 1'b1; pg_space = 16'd6;
    ins_valid = 1'b1; ins_space = 16'd8; ins_vpn = 20'd1; ins_ppn = 20'h00081;
    @(negedge clk);
    pg_valid = 1'b0; ins_valid = 1'b0;
    look(16'd8, 20'd1, 1'b0, 20'h0,     "R9 insert dropped beside purge");
    look(16'd6, 20'd1, 1'b0, 20'h0,     "R9 purge applied");
    look(16'd7, 20'd9, 1'b1, 20'h00079, "R9 unrelated space kept");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 scoreboard drain: %0d left, expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule